// File: doc/BRIEF.md
# Shadow and Hole Memory Router

This block decides, for each host memory access in the legacy area below 1 MB and in the low extended area, whether internal DRAM serves it or the external bus does. Reads and writes are decided separately. Sixteen 16 KB segments cover 0xC0000 to 0xFFFFF. Each segment has its own read-enable bit and its own write-enable bit. A set bit keeps that kind of access in DRAM. A clear bit sends it out to the bus. Around these segments there are fixed holes. A graphics window and a base-memory window each have a control bit. Two 1 MB windows near the 16 MB line exist only when installed memory reaches past their start.

Software programs five control bytes through a plain byte write port. Accesses arrive on a valid/ready request channel, carrying an address and a write flag. The installed memory size is a plain input that is sampled in the cycle the request is accepted. One cycle after acceptance, the decision appears on a valid/ready response channel. The response is a single bit, `rsp_ext`: 1 means the external bus and 0 means internal DRAM.

Back-pressure rules:
- A request is taken on any clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high when the response slot is empty or the slot is being drained in the same cycle.
- While `rsp_valid` is high and `rsp_ready` is low, the response holds still and no request is taken.

Two plain status outputs report whether any segment in the BIOS area (0xE0000 and above) has reads shadowed, and whether any has writes shadowed.

Top module: `shadow_hole_router`

## Requirements
- R1: After reset all five control bytes are zero. As a result, every legacy segment and the 0xA0000–0xBFFFF window route to the external bus, 0x80000–0x9FFFF routes to DRAM, and both status outputs are 0.
- R2: Segment i covers 0xC0000 + i·0x4000 for 16 KB. Its read-enable bit is bit (i mod 8) of config byte 0 when i < 8, and of config byte 1 otherwise.
- R3: The write-enable bit of segment i is bit (i mod 8) of config byte 2 when i < 8, and of config byte 3 otherwise. Read routing and write routing of a segment do not affect each other.
- R4: Inside 0xC0000–0xFFFFF, an access whose enable bit is set gives `rsp_ext`=0. An access whose enable bit is clear gives `rsp_ext`=1.
- R5: Config byte 4 is the hole byte. Its bit 3 set routes 0xA0000–0xBFFFF to DRAM, and clear routes it to the bus. Its bit 2 set routes 0x80000–0x9FFFF to the bus, and clear routes it to DRAM.
- R6: Hole-byte bit 5 routes 0xE00000–0xEFFFFF to the bus when `mem_size` > 0xE00000. Bit 4 does the same for 0xF00000–0xFFFFFF when `mem_size` > 0xF00000.
- R7: Any other address routes to DRAM when it is below `mem_size` and to the bus when it is at or above `mem_size`.
- R8: `bios_rd_shadowed` is 1 exactly when a read enable of some segment 8..15 is set. `bios_wr_shadowed` follows the same rule with the write enables.
- R9: Hole-byte bits 1:0 have no effect. Writes to config addresses 5, 6 and 7 have no effect.
- R10: The handshake works as follows:
  - A request taken at an edge gives `rsp_valid`=1 after that edge.
  - `req_ready` = !`rsp_valid` || `rsp_ready`.
  - A stalled response keeps its value.
- R11: A config write takes effect from the next clock edge. A request accepted on the same edge as the write is routed with the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Config byte write strobe |
| cfg_addr | input | 3 | Config byte select (0..4 used) |
| cfg_wdata | input | 8 | Config byte value |
| mem_size | input | 32 | Installed memory size in bytes |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Routing decision valid |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_ext | output | 1 | 1 = external bus, 0 = internal DRAM |
| bios_rd_shadowed | output | 1 | Some BIOS-area segment is read-shadowed |
| bios_wr_shadowed | output | 1 | Some BIOS-area segment is write-shadowed |

## Verification
The assertions assume the following about the inputs:
- Inputs are never X after reset.
- The block uses its default geometry, so config bytes 1 and 3 cover exactly the BIOS segments.
- `mem_size` is meaningful only in the cycle a request is taken.

The stimulus drives every input on the falling edge and holds `rsp_ready` high except in the stall scenario. Each request it issues is taken in one cycle, except in the stall scenario, which deliberately presents a second request against a full response slot.

// File: rtl/shr_pkg.sv
package shr_pkg;
  // Hole byte as stored: config bits 7:2, most significant first.
  typedef struct packed {
    logic [1:0] spare;
    logic       e_win_ext;
    logic       f_win_ext;
    logic       vga_dram;
    logic       base_win_ext;
  } hole_cfg_t;

  localparam int unsigned HOLE_KEEP_LSB = 2;

  function automatic hole_cfg_t hole_from_byte(input logic [7:0] b);
    return hole_cfg_t'(b[7:HOLE_KEEP_LSB]);
  endfunction

  function automatic logic in_window(input logic [63:0] addr,
                                     input logic [63:0] base,
                                     input logic [63:0] span);
    return (addr >= base) && (addr < base + span);
  endfunction
endpackage

// File: rtl/shr_cfg_regs.sv
module shr_cfg_regs
  import shr_pkg::*;
#(
  parameter  int SEG_COUNT = 16,
  localparam int NB        = SEG_COUNT / 8,
  localparam int CFG_AW    = $clog2(2 * NB + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [7:0]           cfg_wdata,
  output logic [SEG_COUNT-1:0] rd_en,
  output logic [SEG_COUNT-1:0] wr_en,
  output hole_cfg_t            hole
);
  localparam logic [CFG_AW-1:0] HOLE_SEL = CFG_AW'(2 * NB);

  logic [7:0] rd_q [NB];
  logic [7:0] wr_q [NB];
  hole_cfg_t  hole_q;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam logic [CFG_AW-1:0] RD_SEL = CFG_AW'(b);
    localparam logic [CFG_AW-1:0] WR_SEL = CFG_AW'(NB + b);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           rd_q[b] <= '0;
      else if (cfg_we && cfg_addr == RD_SEL) rd_q[b] <= cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           wr_q[b] <= '0;
      else if (cfg_we && cfg_addr == WR_SEL) wr_q[b] <= cfg_wdata;
    end

    assign rd_en[b*8 +: 8] = rd_q[b];
    assign wr_en[b*8 +: 8] = wr_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             hole_q <= '0;
    else if (cfg_we && cfg_addr == HOLE_SEL) hole_q <= hole_from_byte(cfg_wdata);
  end

  assign hole = hole_q;
endmodule

// File: rtl/shr_seg_lookup.sv
module shr_seg_lookup #(
  parameter  int                ADDR_W     = 32,
  parameter  int                SEG_COUNT  = 16,
  parameter  int                SEG_SHIFT  = 14,
  parameter  logic [ADDR_W-1:0] BASE       = ADDR_W'(32'h000C_0000),
  parameter  logic [ADDR_W-1:0] BIOS_START = ADDR_W'(32'h000E_0000),
  localparam int                IDX_W      = $clog2(SEG_COUNT)
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 is_write,
  input  logic [SEG_COUNT-1:0] rd_en,
  input  logic [SEG_COUNT-1:0] wr_en,
  output logic                 hit,
  output logic                 to_dram,
  output logic                 bios_rd,
  output logic                 bios_wr
);
  localparam logic [ADDR_W-1:0] SPAN      = ADDR_W'(SEG_COUNT) << SEG_SHIFT;
  localparam int                BIOS_FIRST = int'((BIOS_START - BASE) >> SEG_SHIFT);

  function automatic logic [SEG_COUNT-1:0] bios_mask_f();
    logic [SEG_COUNT-1:0] m;
    for (int i = 0; i < SEG_COUNT; i++) m[i] = (i >= BIOS_FIRST);
    return m;
  endfunction

  localparam logic [SEG_COUNT-1:0] BIOS_MASK = bios_mask_f();

  logic [ADDR_W-1:0]    offset;
  logic [IDX_W-1:0]     idx;
  logic [SEG_COUNT-1:0] sel_en;

  always_comb begin
    offset  = addr - BASE;
    hit     = (addr >= BASE) && (offset < SPAN);
    idx     = offset[SEG_SHIFT +: IDX_W];
    sel_en  = is_write ? wr_en : rd_en;
    to_dram = sel_en[idx];
  end

  assign bios_rd = |(rd_en & BIOS_MASK);
  assign bios_wr = |(wr_en & BIOS_MASK);
endmodule

// File: rtl/shr_hole_decode.sv
module shr_hole_decode
  import shr_pkg::*;
#(
  parameter logic [31:0] ADDR_W_DUMMY = 0,
  parameter int          ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] BASE_WIN = ADDR_W'(32'h0008_0000),
  parameter logic [ADDR_W-1:0] VGA_WIN  = ADDR_W'(32'h000A_0000),
  parameter logic [ADDR_W-1:0] LOW_SPAN = ADDR_W'(32'h0002_0000),
  parameter logic [ADDR_W-1:0] E_WIN    = ADDR_W'(32'h00E0_0000),
  parameter logic [ADDR_W-1:0] F_WIN    = ADDR_W'(32'h00F0_0000),
  parameter logic [ADDR_W-1:0] HI_SPAN  = ADDR_W'(32'h0010_0000)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] mem_size,
  input  hole_cfg_t         hole,
  output logic              ext
);
  logic in_base, in_vga, in_e, in_f;

  always_comb begin
    in_base = in_window(64'(addr), 64'(BASE_WIN), 64'(LOW_SPAN));
    in_vga  = in_window(64'(addr), 64'(VGA_WIN),  64'(LOW_SPAN));
    in_e    = in_window(64'(addr), 64'(E_WIN),    64'(HI_SPAN)) && (mem_size > E_WIN);
    in_f    = in_window(64'(addr), 64'(F_WIN),    64'(HI_SPAN)) && (mem_size > F_WIN);

    if (in_vga)                        ext = !hole.vga_dram;
    else if (in_base)                  ext = hole.base_win_ext;
    else if (in_e && hole.e_win_ext)   ext = 1'b1;
    else if (in_f && hole.f_win_ext)   ext = 1'b1;
    else                               ext = (addr >= mem_size);
  end
endmodule

// File: rtl/shadow_hole_router.sv
module shadow_hole_router
  import shr_pkg::*;
#(
  parameter  int ADDR_W    = 32,
  parameter  int SEG_COUNT = 16,
  parameter  int SEG_SHIFT = 14,
  localparam int NB        = SEG_COUNT / 8,
  localparam int CFG_AW    = $clog2(2 * NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [ADDR_W-1:0] mem_size,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ext,
  output logic              bios_rd_shadowed,
  output logic              bios_wr_shadowed
);
  logic [SEG_COUNT-1:0] rd_en, wr_en;
  hole_cfg_t            hole;
  logic                 seg_hit, seg_dram, hole_ext, route_ext, take;

  shr_cfg_regs #(.SEG_COUNT(SEG_COUNT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .hole     (hole)
  );

  shr_seg_lookup #(
    .ADDR_W   (ADDR_W),
    .SEG_COUNT(SEG_COUNT),
    .SEG_SHIFT(SEG_SHIFT)
  ) u_seg (
    .addr    (req_addr),
    .is_write(req_write),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .hit     (seg_hit),
    .to_dram (seg_dram),
    .bios_rd (bios_rd_shadowed),
    .bios_wr (bios_wr_shadowed)
  );

  shr_hole_decode #(.ADDR_W(ADDR_W)) u_hole (
    .addr    (req_addr),
    .mem_size(mem_size),
    .hole    (hole),
    .ext     (hole_ext)
  );

  assign route_ext = seg_hit ? !seg_dram : hole_ext;
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ext   <= 1'b0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_ext   <= route_ext;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/shr_checker.sv
module shr_checker #(
  parameter int ADDR_W = 32,
  parameter int CFG_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic [ADDR_W-1:0] mem_size,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_ext,
  input logic              bios_rd_shadowed,
  input logic              bios_wr_shadowed
);
  logic plain_addr;
  assign plain_addr = (req_addr >= ADDR_W'(32'h0010_0000)) && (req_addr < ADDR_W'(32'h00E0_0000));

  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R10
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ext)); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R10
  AST_PLAIN_BELOW_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && plain_addr && req_addr < mem_size |=> !rsp_ext); // R7
  AST_PLAIN_ABOVE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && plain_addr && req_addr >= mem_size |=> rsp_ext); // R7
  AST_BIOS_RD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == CFG_AW'(1) |=> bios_rd_shadowed == (|$past(cfg_wdata))); // R8
  AST_BIOS_WR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == CFG_AW'(3) |=> bios_wr_shadowed == (|$past(cfg_wdata))); // R8
endmodule

bind shadow_hole_router shr_checker #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_we          (cfg_we),
  .cfg_addr        (cfg_addr),
  .cfg_wdata       (cfg_wdata),
  .mem_size        (mem_size),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_addr        (req_addr),
  .rsp_valid       (rsp_valid),
  .rsp_ready       (rsp_ready),
  .rsp_ext         (rsp_ext),
  .bios_rd_shadowed(bios_rd_shadowed),
  .bios_wr_shadowed(bios_wr_shadowed)
);

// File: tb/test_shadow_hole_router.sv
module test_shadow_hole_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [31:0] mem_size = 32'h0100_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_ext;
  logic        bios_rd_shadowed, bios_wr_shadowed;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shadow_hole_router i_shadow_hole_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mem_size(mem_size), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ext(rsp_ext),
    .bios_rd_shadowed(bios_rd_shadowed), .bios_wr_shadowed(bios_wr_shadowed)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic w, input logic exp);
    @(negedge clk);
    req_addr = a; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check(tag, 32'(rsp_ext), 32'(exp));
  endtask

  task automatic clear_all();
    for (int k = 0; k < 5; k++) cfg(3'(k), 8'h00);
    mem_size = 32'h0100_0000;
  endtask

  task automatic t_reset();
    check("R1 bios_rd at reset", 32'(bios_rd_shadowed), 0);
    check("R1 bios_wr at reset", 32'(bios_wr_shadowed), 0);
    check("R1 rsp_valid at reset", 32'(rsp_valid), 0);
    probe("R1 read C0000", 32'h000C_0000, 1'b0, 1'b1);
    probe("R1 write F0000", 32'h000F_0000, 1'b1, 1'b1);
    probe("R1 read A0000", 32'h000A_0000, 1'b0, 1'b1);
    probe("R1 read 80000", 32'h0008_0000, 1'b0, 1'b0);
  endtask

  task automatic t_read_segments();
    clear_all();
    cfg(3'd0, 8'h05);
    cfg(3'd1, 8'h80);
    probe("R2 R4 read seg0", 32'h000C_0000, 1'b0, 1'b0);
    probe("R2 R4 read seg1", 32'h000C_4000, 1'b0, 1'b1);
    probe("R2 read seg2", 32'h000C_8123, 1'b0, 1'b0);
    probe("R2 read seg15 top", 32'h000F_FFFF, 1'b0, 1'b0);
    probe("R2 read seg14", 32'h000F_BFFF, 1'b0, 1'b1);
    probe("R3 write seg0 ignores read bit", 32'h000C_0000, 1'b1, 1'b1);
    check("R8 bios_rd set", 32'(bios_rd_shadowed), 1);
    check("R8 bios_wr clear", 32'(bios_wr_shadowed), 0);
  endtask

  task automatic t_write_segments();
    clear_all();
    cfg(3'd2, 8'h02);
    cfg(3'd3, 8'h01);
    probe("R3 write seg1", 32'h000C_4000, 1'b1, 1'b0);
    probe("R3 read seg1 ignores write bit", 32'h000C_4000, 1'b0, 1'b1);
    probe("R3 write seg8", 32'h000E_3FFF, 1'b1, 1'b0);
    probe("R3 write seg9", 32'h000E_4000, 1'b1, 1'b1);
    check("R8 bios_wr set", 32'(bios_wr_shadowed), 1);
    check("R8 bios_rd clear", 32'(bios_rd_shadowed), 0);
    cfg(3'd3, 8'h00);
    check("R8 bios_wr cleared", 32'(bios_wr_shadowed), 0);
  endtask

  task automatic t_low_holes();
    clear_all();
    cfg(3'd4, 8'h08);
    probe("R5 vga read dram", 32'h000A_0000, 1'b0, 1'b0);
    probe("R5 vga write dram", 32'h000B_FFFF, 1'b1, 1'b0);
    probe("R5 base dram", 32'h0008_0000, 1'b0, 1'b0);
    cfg(3'd4, 8'h04);
    probe("R5 vga ext", 32'h000A_0000, 1'b0, 1'b1);
    probe("R5 base ext", 32'h0009_FFFF, 1'b0, 1'b1);
    probe("R5 below base dram", 32'h0007_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_upper_holes();
    clear_all();
    cfg(3'd4, 8'h20);
    probe("R6 E hole start", 32'h00E0_0000, 1'b0, 1'b1);
    probe("R6 E hole end", 32'h00EF_FFFF, 1'b1, 1'b1);
    probe("R6 F not holed", 32'h00F0_0000, 1'b0, 1'b0);
    probe("R6 below E", 32'h00DF_FFFF, 1'b0, 1'b0);
    cfg(3'd4, 8'h10);
    probe("R6 F hole", 32'h00F0_0000, 1'b0, 1'b1);
    probe("R6 E not holed", 32'h00E0_0000, 1'b0, 1'b0);
    mem_size = 32'h00F0_0000;
    cfg(3'd4, 8'h20);
    probe("R6 E hole small mem", 32'h00E8_0000, 1'b0, 1'b1);
    cfg(3'd4, 8'h00);
    probe("R6 E no hole small mem", 32'h00E8_0000, 1'b0, 1'b0);
    mem_size = 32'h00E0_0000;
    probe("R7 E beyond mem", 32'h00E0_0000, 1'b0, 1'b1);
  endtask

  task automatic t_mem_limit();
    clear_all();
    mem_size = 32'h0040_0000;
    probe("R7 below size", 32'h003F_FFFF, 1'b0, 1'b0);
    probe("R7 at size", 32'h0040_0000, 1'b1, 1'b1);
    probe("R7 low base mem", 32'h0001_0000, 1'b0, 1'b0);
  endtask

  task automatic t_ignored();
    clear_all();
    cfg(3'd4, 8'h03);
    probe("R9 hole bits1:0 vga", 32'h000A_0000, 1'b0, 1'b1);
    probe("R9 hole bits1:0 base", 32'h0008_0000, 1'b0, 1'b0);
    cfg(3'd5, 8'hFF);
    cfg(3'd6, 8'hFF);
    cfg(3'd7, 8'hFF);
    probe("R9 addr5-7 seg read", 32'h000C_0000, 1'b0, 1'b1);
    probe("R9 addr5-7 seg write", 32'h000F_C000, 1'b1, 1'b1);
    probe("R9 addr5-7 vga", 32'h000A_0000, 1'b0, 1'b1);
    check("R9 bios_rd", 32'(bios_rd_shadowed), 0);
    check("R9 bios_wr", 32'(bios_wr_shadowed), 0);
  endtask

  task automatic t_cfg_timing();
    clear_all();
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'h01;
    req_addr = 32'h000C_0000; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R11 same-edge uses old", 32'(rsp_ext), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 next uses new", 32'(rsp_ext), 0);
  endtask

  task automatic t_backpressure();
    clear_all();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr = 32'h000A_0000; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    check("R10 first rsp valid", 32'(rsp_valid), 1);
    check("R10 first rsp value", 32'(rsp_ext), 1);
    req_addr = 32'h0008_0000;
    #1;
    check("R10 ready low when full", 32'(req_ready), 0);
    @(negedge clk);
    check("R10 stall holds valid", 32'(rsp_valid), 1);
    check("R10 stall holds value", 32'(rsp_ext), 1);
    rsp_ready = 1'b1;
    #1;
    check("R10 ready when draining", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 second rsp valid", 32'(rsp_valid), 1);
    check("R10 second rsp value", 32'(rsp_ext), 0);
    @(negedge clk);
    check("R10 drained", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_segments();
    t_write_segments();
    t_low_holes();
    t_upper_holes();
    t_mem_limit();
    t_ignored();
    t_cfg_timing();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule